// File: doc/BRIEF.md
# Connection Memory Fill Engine

This block fills two connection memories, a local one and a backplane one, with a fixed word under software control. The fill is much faster than a processor writing every location in turn. Software arms the fill by writing a one into a fill-enable bit while the master fill bit of the control register is set. The engine then sweeps every address, from zero upward, and writes one local and one backplane location in each clock cycle.

Each word written carries a 3-bit pattern in its top bits, and every other bit of the word is zero. The local memory and the backplane memory each have their own pattern field. When the sweep ends, the enable bit clears itself. Software can stop a fill at any time in either of two ways: by writing the enable bit low, or by dropping the master fill bit.

While no fill runs, processor writes pass straight through to the selected memory. While a fill runs, processor writes are held off and a busy flag is raised.

Top module: `cmfill_top`

## Requirements
- R1: After reset the enable bit reads 0, the busy flag is 0, both pattern fields hold 0, and neither memory write enable is asserted.
- R2: A write of 1 to the enable bit, while the bit reads 0 and the master fill bit is 1, starts a fill. From the next cycle, both memories are written in every cycle. The addresses start at 0 and rise by one per cycle, and the local and backplane addresses are equal.
- R3: Each fill word holds the pattern in bits [WORD_W-1:WORD_W-3], with zero in all lower bits. The local memory takes the local pattern and the backplane memory takes the backplane pattern. Both patterns are captured when the fill starts, so changing the pattern inputs during a fill has no effect.
- R4: The enable bit reads 1 and busy is 1 during a fill. A complete fill writes exactly DEPTH locations. In the cycle after address DEPTH-1 is written, the enable bit reads 0 and busy is 0.
- R5: Writing 1 to the enable bit while it already reads 1 does not restart the sweep: the address keeps counting.
- R6: Writing 0 to the enable bit during a fill aborts it. From the next cycle, no fill writes occur and the enable bit reads 0.
- R7: A master fill bit of 0, sampled at a clock edge during a fill, aborts the fill from the next cycle, and the enable bit reads 0.
- R8: A write of 1 to the enable bit while the master fill bit is 0 is ignored: the enable bit stays 0 and no memory is written.
- R9: When idle, a processor write goes only to the memory picked by the select input (0 = local, 1 = backplane), with the processor's address and data. During a fill, processor writes are not passed on and busy is 1.
- R10: Zero patterns are legal: a fill with both patterns 0 writes all-zero words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enWrite | input | 1 | Strobe: register write to the fill-enable bit |
| enWriteVal | input | 1 | Value written to the fill-enable bit |
| masterFill | input | 1 | Master fill bit from the control register |
| locPatIn | input | PAT_W | Local pattern field |
| bpPatIn | input | PAT_W | Backplane pattern field |
| enableRd | output | 1 | Read-back of the fill-enable bit |
| busy | output | 1 | Fill in progress; processor writes held off |
| cpuWrEn | input | 1 | Processor connection-memory write request |
| cpuSel | input | 1 | Processor target: 0 local, 1 backplane |
| cpuAddr | input | ADDR_W | Processor write address |
| cpuData | input | WORD_W | Processor write data |
| locWe | output | 1 | Local memory write enable |
| locAddr | output | ADDR_W | Local memory address |
| locData | output | WORD_W | Local memory write data |
| bpWe | output | 1 | Backplane memory write enable |
| bpAddr | output | ADDR_W | Backplane memory address |
| bpData | output | WORD_W | Backplane memory write data |

## Verification
The bench builds the engine with DEPTH set to 16, WORD_W to 16 and PAT_W to 3. With DEPTH at 16, a complete sweep lasts only sixteen cycles, so the bench can check every address of a fill, and the self-clearing edge after the last address, many times over. The same short sweep also brings the following cases within reach: a restart attempt part-way through a fill, both kinds of abort at chosen addresses, and a pattern change in mid-fill. The width of 16 keeps the 3-bit pattern in bits 15 to 13, with 13 bits below it that must stay zero.

// File: rtl/cmfill_pkg.sv
package cmfill_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic start;   // begin sweep at address 0, capture patterns
    logic step;    // advance address
    logic fillOn;  // sweep owns the memory ports this cycle
  } fill_ctl_t;
endpackage

// File: rtl/cmfill_ctrl.sv
module cmfill_ctrl
  import cmfill_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      enWrite,
  input  logic      enWriteVal,
  input  logic      masterFill,
  input  logic      lastAddr,
  output fill_ctl_t ctl,
  output logic      enBit
);
  logic active;
  logic wantOn, wantOff, startReq, abortReq, finishReq;

  always_comb begin
    wantOn    = enWrite && enWriteVal;
    wantOff   = enWrite && !enWriteVal;
    startReq  = wantOn && !enBit && masterFill;
    abortReq  = active && (wantOff || !masterFill);
    finishReq = active && lastAddr && !abortReq;
    ctl.start  = startReq;
    ctl.step   = active && !abortReq && !finishReq;
    ctl.fillOn = active;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      enBit  <= 1'b0;
    end else begin
      if (startReq) begin
        active <= 1'b1;
        enBit  <= 1'b1;
      end else if (abortReq || finishReq) begin
        active <= 1'b0;
        enBit  <= 1'b0;
      end else if (wantOff) begin
        enBit  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cmfill_dpath.sv
module cmfill_dpath
  import cmfill_pkg::*;
#(
  parameter int DEPTH  = 8192,
  parameter int WORD_W = 16,
  parameter int PAT_W  = 3,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fill_ctl_t         ctl,
  input  logic [PAT_W-1:0]  locPatIn,
  input  logic [PAT_W-1:0]  bpPatIn,
  input  logic              cpuWrEn,
  input  logic              cpuSel,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [WORD_W-1:0] cpuData,
  output logic              lastAddr,
  output logic              locWe,
  output logic [ADDR_W-1:0] locAddr,
  output logic [WORD_W-1:0] locData,
  output logic              bpWe,
  output logic [ADDR_W-1:0] bpAddr,
  output logic [WORD_W-1:0] bpData
);
  localparam int LOW_W = WORD_W - PAT_W;
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] sweepAddr;
  logic [PAT_W-1:0]  locPat, bpPat;
  logic [WORD_W-1:0] locFillWord, bpFillWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sweepAddr <= '0;
      locPat    <= '0;
      bpPat     <= '0;
    end else if (ctl.start) begin
      sweepAddr <= '0;
      locPat    <= locPatIn;
      bpPat     <= bpPatIn;
    end else if (ctl.step) begin
      sweepAddr <= sweepAddr + 1'b1;
    end
  end

  assign lastAddr    = (sweepAddr == LAST);
  assign locFillWord = {locPat, {LOW_W{1'b0}}};
  assign bpFillWord  = {bpPat,  {LOW_W{1'b0}}};

  always_comb begin
    if (ctl.fillOn) begin
      locWe = 1'b1;  locAddr = sweepAddr; locData = locFillWord;
      bpWe  = 1'b1;  bpAddr  = sweepAddr; bpData  = bpFillWord;
    end else begin
      locWe = cpuWrEn && !cpuSel; locAddr = cpuAddr; locData = cpuData;
      bpWe  = cpuWrEn &&  cpuSel; bpAddr  = cpuAddr; bpData  = cpuData;
    end
  end
endmodule

// File: rtl/cmfill_top.sv
module cmfill_top
  import cmfill_pkg::*;
#(
  parameter int DEPTH  = 8192,
  parameter int WORD_W = 16,
  parameter int PAT_W  = 3,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enWrite,
  input  logic              enWriteVal,
  input  logic              masterFill,
  input  logic [PAT_W-1:0]  locPatIn,
  input  logic [PAT_W-1:0]  bpPatIn,
  output logic              enableRd,
  output logic              busy,
  input  logic              cpuWrEn,
  input  logic              cpuSel,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [WORD_W-1:0] cpuData,
  output logic              locWe,
  output logic [ADDR_W-1:0] locAddr,
  output logic [WORD_W-1:0] locData,
  output logic              bpWe,
  output logic [ADDR_W-1:0] bpAddr,
  output logic [WORD_W-1:0] bpData
);
  fill_ctl_t ctl;
  logic      lastAddr;

  cmfill_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .enWrite(enWrite), .enWriteVal(enWriteVal),
    .masterFill(masterFill), .lastAddr(lastAddr), .ctl(ctl), .enBit(enableRd)
  );

  cmfill_dpath #(.DEPTH(DEPTH), .WORD_W(WORD_W), .PAT_W(PAT_W), .ADDR_W(ADDR_W)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .locPatIn(locPatIn), .bpPatIn(bpPatIn),
    .cpuWrEn(cpuWrEn), .cpuSel(cpuSel), .cpuAddr(cpuAddr), .cpuData(cpuData),
    .lastAddr(lastAddr), .locWe(locWe), .locAddr(locAddr), .locData(locData),
    .bpWe(bpWe), .bpAddr(bpAddr), .bpData(bpData)
  );

  assign busy = ctl.fillOn;
endmodule

// File: rtl/cmfill_chk.sv
module cmfill_chk #(
  parameter int DEPTH  = 8192,
  parameter int WORD_W = 16,
  parameter int PAT_W  = 3,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rstN,
  input logic              enWrite,
  input logic              enWriteVal,
  input logic              masterFill,
  input logic              enableRd,
  input logic              busy,
  input logic              locWe,
  input logic [ADDR_W-1:0] locAddr,
  input logic [WORD_W-1:0] locData,
  input logic              bpWe,
  input logic [ADDR_W-1:0] bpAddr,
  input logic [WORD_W-1:0] bpData
);
  localparam int LOW_W = WORD_W - PAT_W;

  assert_fill_starts_at_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (locWe && bpWe && locAddr == '0 && bpAddr == '0));

  assert_addr_counts_up_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> (locAddr == ADDR_W'($past(locAddr) + 1'b1)));

  assert_fill_word_stable_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> ($stable(locData) && $stable(bpData)));

  assert_low_bits_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (locData[LOW_W-1:0] == '0 && bpData[LOW_W-1:0] == '0));

  assert_enable_while_busy_R4: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (enableRd && locWe && bpWe && locAddr == bpAddr));

  assert_write_zero_aborts_R6: assert property (@(posedge clk) disable iff (!rstN)
    (enWrite && !enWriteVal) |=> (!busy && !enableRd));

  assert_master_low_aborts_R7: assert property (@(posedge clk) disable iff (!rstN)
    !masterFill |=> !busy);

  assert_start_needs_master_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!enableRd && enWrite && enWriteVal && !masterFill) |=> !enableRd);
endmodule

bind cmfill_top cmfill_chk #(.DEPTH(DEPTH), .WORD_W(WORD_W), .PAT_W(PAT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .enWrite(enWrite), .enWriteVal(enWriteVal),
  .masterFill(masterFill), .enableRd(enableRd), .busy(busy),
  .locWe(locWe), .locAddr(locAddr), .locData(locData),
  .bpWe(bpWe), .bpAddr(bpAddr), .bpData(bpData)
);

// File: tb/tb_cmfill_top.sv
module tb_cmfill_top;
  localparam int DEPTH  = 16;
  localparam int WORD_W = 16;
  localparam int PAT_W  = 3;
  localparam int ADDR_W = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enWrite = 1'b0, enWriteVal = 1'b0, masterFill = 1'b1;
  logic [PAT_W-1:0] locPatIn = '0, bpPatIn = '0;
  logic enableRd, busy;
  logic cpuWrEn = 1'b0, cpuSel = 1'b0;
  logic [ADDR_W-1:0] cpuAddr = '0;
  logic [WORD_W-1:0] cpuData = '0;
  logic locWe, bpWe;
  logic [ADDR_W-1:0] locAddr, bpAddr;
  logic [WORD_W-1:0] locData, bpData;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  cmfill_top #(.DEPTH(DEPTH), .WORD_W(WORD_W), .PAT_W(PAT_W)) dut (
    .clk(clk), .rstN(rstN), .enWrite(enWrite), .enWriteVal(enWriteVal),
    .masterFill(masterFill), .locPatIn(locPatIn), .bpPatIn(bpPatIn),
    .enableRd(enableRd), .busy(busy), .cpuWrEn(cpuWrEn), .cpuSel(cpuSel),
    .cpuAddr(cpuAddr), .cpuData(cpuData), .locWe(locWe), .locAddr(locAddr),
    .locData(locData), .bpWe(bpWe), .bpAddr(bpAddr), .bpData(bpData)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  function automatic int fillWord(input int pat);
    return pat << (WORD_W - PAT_W);
  endfunction

  // Issue a one-cycle write to the enable bit; returns at the negedge after the edge
  task automatic writeEn(input bit v);
    enWrite = 1'b1; enWriteVal = v;
    tick();
    enWrite = 1'b0;
  endtask

  task automatic test_reset;
    chk(enableRd == 0, "R1 enable", enableRd, 0);
    chk(busy == 0, "R1 busy", busy, 0);
    chk(locWe == 0 && bpWe == 0, "R1 write enables", locWe + bpWe, 0);
  endtask

  // Full fill; patterns changed at address 3 must be ignored (R3)
  task automatic test_full_fill(input int lp, input int bp, input string req);
    int writes = 0;
    locPatIn = PAT_W'(lp); bpPatIn = PAT_W'(bp);
    writeEn(1'b1);
    for (int i = 0; i < DEPTH; i++) begin
      if (i == 3) begin locPatIn = ~PAT_W'(lp); bpPatIn = ~PAT_W'(bp); end
      chk(locWe && bpWe, "R2 both written", locWe + bpWe, 2);
      chk(int'(locAddr) == i && int'(bpAddr) == i, "R2 address", int'(locAddr), i);
      chk(int'(locData) == fillWord(lp), {req, " local word"}, int'(locData), fillWord(lp));
      chk(int'(bpData) == fillWord(bp), {req, " backplane word"}, int'(bpData), fillWord(bp));
      chk(enableRd && busy, "R4 enable high during fill", enableRd, 1);
      if (locWe) writes++;
      tick();
    end
    chk(writes == DEPTH, "R4 write count", writes, DEPTH);
    chk(!enableRd && !busy, "R4 self clear", enableRd, 0);
    chk(!locWe && !bpWe, "R4 writes stop", locWe, 0);
  endtask

  task automatic test_no_restart;
    locPatIn = 3'd2; bpPatIn = 3'd6;
    writeEn(1'b1);
    for (int i = 0; i < 5; i++) tick();
    writeEn(1'b1);  // at edge after addr 5 -> now addr 6
    chk(int'(locAddr) == 6, "R5 address continues", int'(locAddr), 6);
    chk(busy == 1, "R5 still busy", busy, 1);
    for (int i = 6; i < DEPTH; i++) tick();
    chk(!enableRd && !busy, "R5 completes on schedule", enableRd, 0);
  endtask

  task automatic test_abort_write0;
    writeEn(1'b1);
    for (int i = 0; i < 4; i++) tick();
    writeEn(1'b0);
    chk(!busy && !enableRd, "R6 abort by write 0", enableRd, 0);
    chk(!locWe && !bpWe, "R6 no fill writes", locWe, 0);
    tick();
    chk(!locWe && !bpWe, "R6 stays stopped", locWe, 0);
  endtask

  task automatic test_abort_master;
    writeEn(1'b1);
    for (int i = 0; i < 3; i++) tick();
    masterFill = 1'b0;
    tick();
    chk(!busy && !enableRd, "R7 abort by master bit", enableRd, 0);
    chk(!locWe && !bpWe, "R7 no fill writes", locWe, 0);
    // R8: start request while master bit low is ignored
    writeEn(1'b1);
    chk(enableRd == 0, "R8 enable stays low", enableRd, 0);
    chk(!locWe && !bpWe && !busy, "R8 no writes", locWe, 0);
    tick();
    chk(!locWe && !bpWe, "R8 still no writes", locWe, 0);
    masterFill = 1'b1;
    tick();
    chk(enableRd == 0 && !busy, "R8 no late start", enableRd, 0);
  endtask

  task automatic test_cpu;
    cpuWrEn = 1'b1; cpuSel = 1'b0; cpuAddr = 4'd9; cpuData = 16'h1234;
    #1;
    chk(locWe && !bpWe, "R9 idle local select", locWe*2 + bpWe, 2);
    chk(locAddr == 4'd9 && locData == 16'h1234, "R9 local addr/data", int'(locData), 16'h1234);
    cpuSel = 1'b1; cpuAddr = 4'd3; cpuData = 16'h00ff;
    #1;
    chk(bpWe && !locWe, "R9 idle backplane select", locWe*2 + bpWe, 1);
    chk(bpAddr == 4'd3 && bpData == 16'h00ff, "R9 backplane addr/data", int'(bpData), 16'h00ff);
    cpuWrEn = 1'b0;
    locPatIn = 3'd1; bpPatIn = 3'd4;
    writeEn(1'b1);
    cpuWrEn = 1'b1; cpuSel = 1'b0; cpuAddr = 4'd12; cpuData = 16'h0abc;
    tick();
    chk(busy == 1, "R9 busy during fill", busy, 1);
    chk(int'(locData) == fillWord(1) && int'(locAddr) == 1, "R9 cpu write held off", int'(locData), fillWord(1));
    cpuWrEn = 1'b0;
    for (int i = 1; i < DEPTH; i++) tick();
    chk(!busy, "R9 busy clears", busy, 0);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    tick();
    test_reset();
    tick();
    rstN = 1'b1;
    tick();
    test_reset();
    test_full_fill(5, 3, "R3");
    test_no_restart();
    test_abort_write0();
    test_abort_master();
    test_cpu();
    test_full_fill(0, 0, "R10");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule